// File: doc/BRIEF.md
# Exposed Issue-Advanced Dual Arithmetic Pipeline

This block is an execution core with two arithmetic pipes, one for addition and subtraction and one for multiplication, and no hidden sequencing. A pipe moves forward only when an instruction is issued to that same unit. The value that drops out of the last stage on such an issue is written into the register named by the destination field of the issuing instruction, not the instruction that produced it. Software therefore tracks pipe contents itself. A result pushed into a three-deep pipe lands in the destination of the third later issue to that pipe, however many issues to the other unit come in between.

Each instruction arrives as a one-cycle valid pulse with an opcode, two source register indices, a destination index and an immediate. Source operands are read from a 32-entry register file in the cycle of issue. Two chained opcodes advance both pipes together. Each one routes the exit value of one unit into an operand of the other, and the instruction picks the direction. Arithmetic is 32-bit two's-complement integer, with results kept modulo 2^32.

Top module: `xpipe_top`

## Requirements
- R1: While reset is held and after it is released, every stage of both pipes is empty (`addOcc` and `mulOcc` are all zero), no write-back is signalled, and all registers read as zero.
- R2: Opcode 0 (add) and opcode 1 (subtract) insert `rf[srcA] + rf[srcB]` or `rf[srcA] - rf[srcB]` (mod 2^32) into adder stage 0 and shift the adder pipe one stage. The multiplier pipe is untouched.
- R3: Opcode 2 (multiply) inserts the low 32 bits of `rf[srcA] * rf[srcB]` into multiplier stage 0 and shifts only the multiplier pipe. Adder occupancy and contents hold.
- R4: The value leaving a pipe on an issue is written to `dstIdx` of the issuing instruction and shown on `wbValid`/`wbIdx`/`wbData` in that issue cycle. With depth 3, an add's result appears at the third later adder issue, even when multiplies are interleaved.
- R5: When the slot leaving a pipe is empty, no register is written and `wbValid` stays low.
- R6: Opcode 3 (multiplier feeds adder) advances both pipes. The multiplier takes `rf[srcA] * rf[srcB]`. The adder takes the multiplier exit value (zero if that slot is empty) plus `rf[srcB]`. The adder exit is written to `dstIdx`, and the multiplier exit is consumed without being written.
- R7: Opcode 4 (adder feeds multiplier) advances both pipes. The adder takes `rf[srcA] + rf[srcB]`. The multiplier takes the adder exit value (zero if empty) times `rf[srcB]`. The multiplier exit is written to `dstIdx`, and the adder exit is consumed without being written.
- R8: Opcode 5 (load) writes `imm` to `dstIdx` at the next edge and leaves both pipes unchanged.
- R9: Operands are read before the write of the same cycle, so an instruction that names its own write-back register as a source sees the old value.
- R10: A cycle with `issueValid` low, or with opcode 6 or 7, changes no pipe, signals no write-back and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | One-cycle strobe that accepts an instruction |
| opcode | input | 3 | Operation select (0 add, 1 sub, 2 mul, 3 mul-to-add chain, 4 add-to-mul chain, 5 load) |
| srcA | input | 5 | First source register index |
| srcB | input | 5 | Second source register index |
| dstIdx | input | 5 | Destination for the value leaving a pipe, or for the load |
| imm | input | 32 | Load value |
| addOcc | output | 3 | Adder stage valid bits, bit 0 newest |
| mulOcc | output | 3 | Multiplier stage valid bits, bit 0 newest |
| wbValid | output | 1 | A register write happens at the coming edge |
| wbIdx | output | 5 | Register being written |
| wbData | output | 32 | Value being written |

## Verification
A stage that shifts on the wrong unit's issue shows on `addOcc`/`mulOcc` at the very next sample. It also shows later as a write-back value or index that differs from the model on the issue that drains the pipe, at most three issues to that unit later. A corrupted register-file entry stays hidden until an instruction reads it. It then surfaces as a wrong `wbData` once that result leaves its pipe. Long random streams with a small register set keep operands heavily reused, so such corruption is reached quickly. Empty-slot handling shows as a spurious or missing `wbValid` in the first issues after reset.

// File: rtl/xpipe_pkg.sv
package xpipe_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_CHM2A = 3'd3,
    OP_CHA2M = 3'd4,
    OP_LOAD  = 3'd5
  } opcode_e;

  typedef struct packed {
    logic addAdv;
    logic mulAdv;
    logic addFromMul;
    logic mulFromAdd;
    logic isSub;
    logic wbAdd;
    logic wbMul;
    logic wbImm;
  } ctrl_t;
endpackage

// File: rtl/xpipe_ctrl.sv
module xpipe_ctrl
  import xpipe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic [2:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    if (issueValid) begin
      case (opcode)
        OP_ADD:   begin ctrl.addAdv = 1'b1; ctrl.wbAdd = 1'b1; end
        OP_SUB:   begin ctrl.addAdv = 1'b1; ctrl.wbAdd = 1'b1; ctrl.isSub = 1'b1; end
        OP_MUL:   begin ctrl.mulAdv = 1'b1; ctrl.wbMul = 1'b1; end
        OP_CHM2A: begin
          ctrl.addAdv = 1'b1; ctrl.mulAdv = 1'b1;
          ctrl.addFromMul = 1'b1; ctrl.wbAdd = 1'b1;
        end
        OP_CHA2M: begin
          ctrl.addAdv = 1'b1; ctrl.mulAdv = 1'b1;
          ctrl.mulFromAdd = 1'b1; ctrl.wbMul = 1'b1;
        end
        OP_LOAD:  ctrl.wbImm = 1'b1;
        default:  ctrl = '0;
      endcase
    end
  end

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!issueValid || opcode > 3'd5) |-> (ctrl == '0));

  // R6
  chain_both_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && (opcode == OP_CHM2A || opcode == OP_CHA2M)) |-> (ctrl.addAdv && ctrl.mulAdv));

  // R5
  one_wb_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.wbAdd, ctrl.wbMul, ctrl.wbImm}));
endmodule

// File: rtl/xpipe_stage_chain.sv
module xpipe_stage_chain #(
  parameter int W     = 32,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adv,
  input  logic [W-1:0]     inData,
  output logic             exitValid,
  output logic [W-1:0]     exitData,
  output logic [DEPTH-1:0] occ
);
  logic [DEPTH-1:0] vld;
  logic [W-1:0]     dat [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          vld[0] <= 1'b0;
          dat[0] <= '0;
        end else if (adv) begin
          vld[0] <= 1'b1;
          dat[0] <= inData;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN) begin
          vld[i] <= 1'b0;
          dat[i] <= '0;
        end else if (adv) begin
          vld[i] <= vld[i-1];
          dat[i] <= dat[i-1];
        end
      end
    end
  end

  assign exitValid = vld[DEPTH-1];
  assign exitData  = dat[DEPTH-1];
  assign occ       = vld;

  // R2
  insert_fills_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    adv |=> occ[0]);

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adv |=> ($stable(occ) && $stable(exitData)));
endmodule

// File: rtl/xpipe_dpath.sv
module xpipe_dpath
  import xpipe_pkg::*;
#(
  parameter int W         = 32,
  parameter int REGS      = 32,
  parameter int ADD_DEPTH = 3,
  parameter int MUL_DEPTH = 3,
  localparam int IW       = $clog2(REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_t                ctrl,
  input  logic [IW-1:0]        srcA,
  input  logic [IW-1:0]        srcB,
  input  logic [IW-1:0]        dstIdx,
  input  logic [W-1:0]         imm,
  output logic [ADD_DEPTH-1:0] addOcc,
  output logic [MUL_DEPTH-1:0] mulOcc,
  output logic                 wbValid,
  output logic [IW-1:0]        wbIdx,
  output logic [W-1:0]         wbData
);
  logic [W-1:0] rf [REGS];
  logic [W-1:0] opA, opB;
  logic [W-1:0] addExitData, mulExitData;
  logic         addExitValid, mulExitValid;
  logic [W-1:0] addLeft, mulLeft, addIn, mulIn;

  assign opA = rf[srcA];
  assign opB = rf[srcB];

  always_comb begin
    addLeft = ctrl.addFromMul ? (mulExitValid ? mulExitData : '0) : opA;
    mulLeft = ctrl.mulFromAdd ? (addExitValid ? addExitData : '0) : opA;
    addIn   = ctrl.isSub ? (addLeft - opB) : (addLeft + opB);
    mulIn   = mulLeft * opB;
  end

  xpipe_stage_chain #(.W(W), .DEPTH(ADD_DEPTH)) uAddPipe (
    .clk(clk), .rstN(rstN), .adv(ctrl.addAdv), .inData(addIn),
    .exitValid(addExitValid), .exitData(addExitData), .occ(addOcc)
  );

  xpipe_stage_chain #(.W(W), .DEPTH(MUL_DEPTH)) uMulPipe (
    .clk(clk), .rstN(rstN), .adv(ctrl.mulAdv), .inData(mulIn),
    .exitValid(mulExitValid), .exitData(mulExitData), .occ(mulOcc)
  );

  always_comb begin
    wbValid = 1'b0;
    wbData  = '0;
    if (ctrl.wbImm) begin
      wbValid = 1'b1;
      wbData  = imm;
    end else if (ctrl.wbAdd) begin
      wbValid = addExitValid;
      wbData  = addExitData;
    end else if (ctrl.wbMul) begin
      wbValid = mulExitValid;
      wbData  = mulExitData;
    end
  end
  assign wbIdx = dstIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) rf[i] <= '0;
    end else if (wbValid) begin
      rf[wbIdx] <= wbData;
    end
  end

  // R5
  empty_exit_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrl.wbAdd && !addExitValid) || (ctrl.wbMul && !mulExitValid)) |-> !wbValid);

  // R8
  load_writes_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wbImm |=> (rf[$past(dstIdx)] == $past(imm)));
endmodule

// File: rtl/xpipe_top.sv
module xpipe_top
  import xpipe_pkg::*;
#(
  parameter int W         = 32,
  parameter int REGS      = 32,
  parameter int ADD_DEPTH = 3,
  parameter int MUL_DEPTH = 3,
  localparam int IW       = $clog2(REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [2:0]           opcode,
  input  logic [IW-1:0]        srcA,
  input  logic [IW-1:0]        srcB,
  input  logic [IW-1:0]        dstIdx,
  input  logic [W-1:0]         imm,
  output logic [ADD_DEPTH-1:0] addOcc,
  output logic [MUL_DEPTH-1:0] mulOcc,
  output logic                 wbValid,
  output logic [IW-1:0]        wbIdx,
  output logic [W-1:0]         wbData
);
  ctrl_t ctrl;

  xpipe_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opcode(opcode), .ctrl(ctrl)
  );

  xpipe_dpath #(.W(W), .REGS(REGS), .ADD_DEPTH(ADD_DEPTH), .MUL_DEPTH(MUL_DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB), .dstIdx(dstIdx),
    .imm(imm), .addOcc(addOcc), .mulOcc(mulOcc), .wbValid(wbValid), .wbIdx(wbIdx),
    .wbData(wbData)
  );

  // R3
  mul_keeps_adder_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opcode == OP_MUL) |=> $stable(addOcc));

  // R10
  idle_keeps_pipes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> ($stable(addOcc) && $stable(mulOcc)));
endmodule

// File: tb/tb_xpipe_top.sv
module tb_xpipe_top;
  localparam int DEPTH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [4:0]  srcA = '0, srcB = '0, dstIdx = '0;
  logic [31:0] imm = '0;
  logic [2:0]  addOcc, mulOcc;
  logic        wbValid;
  logic [4:0]  wbIdx;
  logic [31:0] wbData;

  int checks = 0;
  int fails  = 0;

  logic [32:0] addQ[$];
  logic [32:0] mulQ[$];
  logic [31:0] mRf [32];
  logic [31:0] seed = 32'h1234_5678;
  logic        sWbValid;
  logic [4:0]  sWbIdx;
  logic [31:0] sWbData;

  always #5 clk = ~clk;

  xpipe_top dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opcode(opcode), .srcA(srcA),
    .srcB(srcB), .dstIdx(dstIdx), .imm(imm), .addOcc(addOcc), .mulOcc(mulOcc),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input bit v, input logic [2:0] op);
    if (!v) return "R10";
    case (op)
      3'd0, 3'd1: return "R2/R4/R5/R9";
      3'd2:       return "R3/R4/R5";
      3'd3:       return "R6";
      3'd4:       return "R7";
      3'd5:       return "R8";
      default:    return "R10";
    endcase
  endfunction

  function automatic logic [2:0] occOf(input bit isAdd);
    logic [2:0] r;
    for (int i = 0; i < DEPTH; i++) r[i] = isAdd ? addQ[i][32] : mulQ[i][32];
    return r;
  endfunction

  task automatic issue(input bit v, input logic [2:0] op, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] d, input logic [31:0] im);
    logic [32:0] aEx, mEx;
    logic [31:0] va, vb, left;
    bit          eV;
    logic [31:0] eD;
    string       tag;
    @(negedge clk);
    issueValid = v; opcode = op; srcA = a; srcB = b; dstIdx = d; imm = im;
    #1;
    tag = tagOf(v, op);
    chk(tag, {29'd0, addOcc}, {29'd0, occOf(1'b1)});
    chk(tag, {29'd0, mulOcc}, {29'd0, occOf(1'b0)});
    va = mRf[a]; vb = mRf[b];
    aEx = addQ[DEPTH-1]; mEx = mulQ[DEPTH-1];
    eV = 1'b0; eD = '0;
    if (v) begin
      case (op)
        3'd0, 3'd1: begin
          void'(addQ.pop_back());
          addQ.push_front({1'b1, (op == 3'd1) ? va - vb : va + vb});
          eV = aEx[32]; eD = aEx[31:0];
        end
        3'd2: begin
          void'(mulQ.pop_back());
          mulQ.push_front({1'b1, va * vb});
          eV = mEx[32]; eD = mEx[31:0];
        end
        3'd3: begin
          left = mEx[32] ? mEx[31:0] : 32'd0;
          void'(addQ.pop_back()); void'(mulQ.pop_back());
          mulQ.push_front({1'b1, va * vb});
          addQ.push_front({1'b1, left + vb});
          eV = aEx[32]; eD = aEx[31:0];
        end
        3'd4: begin
          left = aEx[32] ? aEx[31:0] : 32'd0;
          void'(addQ.pop_back()); void'(mulQ.pop_back());
          addQ.push_front({1'b1, va + vb});
          mulQ.push_front({1'b1, left * vb});
          eV = mEx[32]; eD = mEx[31:0];
        end
        3'd5: begin eV = 1'b1; eD = im; end
        default: ;
      endcase
    end
    chk(tag, {31'd0, wbValid}, {31'd0, eV});
    if (eV) begin
      chk(tag, {27'd0, wbIdx}, {27'd0, d});
      chk(tag, wbData, eD);
      mRf[d] = eD;
    end
    sWbValid = wbValid; sWbIdx = wbIdx; sWbData = wbData;
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin addQ.push_back('0); mulQ.push_back('0); end
    for (int i = 0; i < 32; i++) mRf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", {29'd0, addOcc}, 32'd0);
    chk("R1", {29'd0, mulOcc}, 32'd0);
    chk("R1", {31'd0, wbValid}, 32'd0);
    rstN = 1'b1;

    // R8: load operands
    issue(1, 3'd5, 0, 0, 2, 32'd10);
    issue(1, 3'd5, 0, 0, 3, 32'd20);
    issue(1, 3'd5, 0, 0, 8, 32'd7);
    // R4: result of the first add leaves at the third later adder issue
    issue(1, 3'd0, 2, 3, 4, 0);
    chk("R5", {31'd0, sWbValid}, 32'd0);
    issue(1, 3'd1, 2, 3, 10, 0);
    issue(1, 3'd2, 8, 8, 16, 0);
    issue(1, 3'd0, 2, 8, 19, 0);
    issue(1, 3'd0, 3, 8, 22, 0);
    chk("R4", {31'd0, sWbValid}, 32'd1);
    chk("R4", {27'd0, sWbIdx}, 32'd22);
    chk("R4", sWbData, 32'd30);
    // R10: idle and reserved opcodes leave everything alone
    issue(0, 3'd0, 2, 3, 5, 0);
    issue(1, 3'd6, 2, 3, 5, 0);
    issue(1, 3'd7, 2, 3, 5, 0);
    chk("R10", {31'd0, sWbValid}, 32'd0);
    // R9: self-referencing destination reads the old value
    issue(1, 3'd0, 22, 22, 22, 0);
    issue(1, 3'd0, 22, 22, 22, 0);
    // R6 / R7: chained directions
    issue(1, 3'd3, 2, 3, 11, 0);
    issue(1, 3'd4, 2, 3, 12, 0);
    issue(1, 3'd3, 8, 2, 13, 0);
    issue(1, 3'd4, 8, 3, 14, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      seed = nextRand(seed);
      op = seed[2:0];
      issue(seed[7:4] != 4'd0, op, {2'b0, seed[10:8]}, {2'b0, seed[13:11]},
            {2'b0, seed[16:14]}, {16'd0, seed[31:16]});
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule